// File: doc/BRIEF.md
# Pipelined Array Multiply-Add Unit

This unit computes the unsigned value a·x + y for two WIDTH-bit factors and a WIDTH-bit addend. The result is 2·WIDTH bits wide. The datapath is a one-sided array of carry-save adder rows. Row r forms the multiple a AND x[r] and folds it into a running sum/carry pair. The addend enters the first row in the slot that would otherwise hold a constant zero, so the addition costs no extra hardware. Each row retires one finished low product bit.

A register follows every row. The factor a, the multiplier bits not yet used and the low product bits already finished all travel with their operation, so a new operation can enter on every clock. After the last row, a registered carry-propagate adder merges the sum/carry pair into the upper half of the result.

Top module: `pipe_array_mac`

## Requirements
- R1: When valid_o is high, result_o equals a_i·x_i + y_i of the operation it belongs to, taken as unsigned numbers, over all 2·WIDTH bits.
- R2: An operation sampled with valid_i high at a rising edge shows up with valid_o high after exactly WIDTH+1 rising edges, counting that edge as the first.
- R3: The sum never exceeds (2^WIDTH−1)·2^WIDTH. With a_i, x_i and y_i all ones, result_o is all ones in the upper half and all zeros in the lower half.
- R4: Operations may be presented on every clock with no gaps. Each one yields its own result, in issue order, one per clock.
- R5: In a cycle where no operation was sampled WIDTH+1 edges earlier, valid_o is low and result_o keeps the last result delivered.
- R6: While and after rst_ni is low, valid_o is low and result_o is zero until the first operation completes.
- R7: With y_i = 0 the result is the plain product a_i·x_i. With a_i = 0 or x_i = 0 the result is y_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on a_i, x_i and y_i |
| a_i | input | WIDTH | Multiplicand |
| x_i | input | WIDTH | Multiplier |
| y_i | input | WIDTH | Addend |
| valid_o | output | 1 | result_o holds a completed operation |
| result_o | output | 2·WIDTH | a·x + y |

## Verification
Two things can happen in the same clock: a new operation enters the first row while an older one leaves through the final adder. Other operations sit in the rows between them.

The bench provokes this with long runs of back-to-back random operations, broken by random bubbles. It also applies directed operands that push the carry chain to its limit: all ones for the largest possible sum, and zero factors or a zero addend.

A behavioural delay-line model in the bench predicts, for every cycle, whether valid_o is high and what result_o holds. The design is judged against that prediction on each clock. In bubble cycles the check also confirms that result_o keeps its last value.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int unsigned DEF_W = 8;

  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction
endpackage

// File: rtl/pam_csa_row.sv
module pam_csa_row #(
  parameter int unsigned W = pam_pkg::DEF_W
) (
  input  logic [W-1:0] a_i,
  input  logic         mbit_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [W-2:0] lo_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] lo_o
);
  localparam int unsigned TW = W + 2;

  logic [W-1:0] pp, fs, fc;

  assign pp = a_i & {W{mbit_i}};

  for (genvar j = 0; j < W; j++) begin : g_cell
    assign fs[j] = s_i[j] ^ c_i[j] ^ pp[j];
    assign fc[j] = pam_pkg::maj3(s_i[j], c_i[j], pp[j]);
  end

  // weight drops by one: bit 0 of the sum is a finished product bit
  assign s_o  = {1'b0, fs[W-1:1]};
  assign c_o  = fc;
  assign lo_o = {fs[0], lo_i};

  logic [TW-1:0] in_tot, out_tot;
  assign in_tot  = TW'(s_i) + TW'(c_i) + TW'(pp);
  assign out_tot = ((TW'(s_o) + TW'(c_o)) << 1) + TW'(lo_o[W-1]);

  always_comb begin
    assert_row_value_R1: assert (in_tot == out_tot);
  end
endmodule

// File: rtl/pam_final_add.sv
module pam_final_add #(
  parameter int unsigned W = pam_pkg::DEF_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   s_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   lo_i,
  output logic           valid_o,
  output logic [2*W-1:0] result_o
);
  logic [W:0] hi_sum;

  assign hi_sum = {1'b0, s_i} + {1'b0, c_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= {hi_sum[W-1:0], lo_i};
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !hi_sum[W]);
endmodule

// File: rtl/pipe_array_mac.sv
module pipe_array_mac #(
  parameter int unsigned WIDTH = pam_pkg::DEF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  output logic               valid_o,
  output logic [2*WIDTH-1:0] result_o
);
  localparam int unsigned W   = WIDTH;
  localparam int unsigned LAT = W + 1;
  localparam int unsigned CW  = $clog2(LAT + 2);

  logic         st_vld [W+1];
  logic [W-1:0] st_s   [W+1];
  logic [W-1:0] st_c   [W+1];
  logic [W-1:0] st_lo  [W+1];
  logic [W-1:0] st_a   [W];
  logic [W-1:0] st_x   [W];

  // addend takes the top row's zero slot
  assign st_vld[0] = valid_i;
  assign st_s[0]   = y_i;
  assign st_c[0]   = '0;
  assign st_lo[0]  = '0;
  assign st_a[0]   = a_i;
  assign st_x[0]   = x_i;

  for (genvar r = 0; r < W; r++) begin : g_row
    logic [W-1:0] s_n, c_n, lo_n;
    logic         vld_q;
    logic [W-1:0] s_q, c_q, lo_q;

    pam_csa_row #(.W(W)) u_row (
      .a_i    (st_a[r]),
      .mbit_i (st_x[r][0]),
      .s_i    (st_s[r]),
      .c_i    (st_c[r]),
      .lo_i   (st_lo[r][W-1:1]),
      .s_o    (s_n),
      .c_o    (c_n),
      .lo_o   (lo_n)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        s_q   <= '0;
        c_q   <= '0;
        lo_q  <= '0;
      end else begin
        vld_q <= st_vld[r];
        s_q   <= s_n;
        c_q   <= c_n;
        lo_q  <= lo_n;
      end
    end

    assign st_vld[r+1] = vld_q;
    assign st_s[r+1]   = s_q;
    assign st_c[r+1]   = c_q;
    assign st_lo[r+1]  = lo_q;

    // operand bits travel only while a later row still needs them
    if (r < W - 1) begin : g_fwd
      logic [W-1:0] a_q, x_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q <= '0;
          x_q <= '0;
        end else begin
          a_q <= st_a[r];
          x_q <= {1'b0, st_x[r][W-1:1]};
        end
      end
      assign st_a[r+1] = a_q;
      assign st_x[r+1] = x_q;
    end
  end

  pam_final_add #(.W(W)) u_cpa (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (st_vld[W]),
    .s_i      (st_s[W]),
    .c_i      (st_c[W]),
    .lo_i     (st_lo[W]),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  // operations accepted but not yet delivered
  logic [CW-1:0] fly_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fly_q <= '0;
    else         fly_q <= fly_q + CW'(valid_i) - CW'(valid_o);
  end

  assert_out_has_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fly_q != '0));

  assert_fly_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fly_q <= CW'(LAT));

  assert_result_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o <= {{W{1'b1}}, {W{1'b0}}}));
endmodule

// File: tb/pipe_array_mac_tb.sv
module pipe_array_mac_tb_top;
  localparam int W = 8;
  localparam int LAT = W + 1;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [W-1:0]     a_i = '0, x_i = '0, y_i = '0;
  logic             valid_o;
  logic [2*W-1:0]   result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic           m_v [LAT];
  logic [2*W-1:0] m_r [LAT];
  string          m_t [LAT];
  logic [2*W-1:0] last_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_array_mac #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one cycle: check outputs against the model, then drive the next operation
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] x,
                      input logic [W-1:0] y, input string tag);
    @(negedge clk);
    if (m_v[LAT-1]) begin
      chk(valid_o === 1'b1, "R2 valid_o", 64'(valid_o), 64'd1);
      chk(result_o === m_r[LAT-1], m_t[LAT-1], 64'(result_o), 64'(m_r[LAT-1]));
      last_res = m_r[LAT-1];
    end else begin
      chk(valid_o === 1'b0, "R5 valid_o", 64'(valid_o), 64'd0);
      chk(result_o === last_res, "R5 hold", 64'(result_o), 64'(last_res));
    end
    for (int i = LAT - 1; i > 0; i--) begin
      m_v[i] = m_v[i-1];
      m_r[i] = m_r[i-1];
      m_t[i] = m_t[i-1];
    end
    m_v[0] = v;
    m_r[0] = (2*W)'(a) * (2*W)'(x) + (2*W)'(y);
    m_t[0] = tag;
    valid_i = v;
    a_i = a;
    x_i = x;
    y_i = y;
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin
      m_v[i] = 1'b0;
      m_r[i] = '0;
      m_t[i] = "";
    end
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0, "R6 valid_o in reset", 64'(valid_o), 64'd0);
    chk(result_o === '0, "R6 result_o in reset", 64'(result_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0, "R6 valid_o after reset", 64'(valid_o), 64'd0);
    chk(result_o === '0, "R6 result_o after reset", 64'(result_o), 64'd0);

    // corner operands
    step(1'b1, '1, '1, '1, "R3 all ones");
    step(1'b1, 8'hB7, 8'h5C, 8'h00, "R7 zero addend");
    step(1'b1, 8'h00, 8'hE3, 8'h9A, "R7 zero multiplicand");
    step(1'b1, 8'h6D, 8'h00, 8'h41, "R7 zero multiplier");
    step(1'b1, '1, '1, 8'h00, "R1 largest product");
    step(1'b0, '0, '0, '0, "");
    step(1'b1, 8'h80, 8'h80, 8'hFF, "R1 top bits");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, '0, "");

    // isolated operation: only the latency of R2 decides when it appears
    step(1'b1, 8'h13, 8'h27, 8'h05, "R2 single op");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, '0, "");

    // back-to-back burst
    for (int i = 0; i < 3 * LAT; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), "R4 burst");

    // random traffic with bubbles
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      step(v, W'($urandom), W'($urandom), W'($urandom), "R1 random");
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, '0, "");
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    summary();
  end
endmodule